// File: doc/BRIEF.md
# Multi-Cycle 16-Bit Load/Store Processor Core

This block is a small processor core that runs a subset of a fixed 16-bit instruction encoding. It holds eight 16-bit general registers, a program counter and a three-bit condition register. It talks to one word-addressed memory through a single synchronous port. A read issued in one cycle returns its data in the next cycle. Each instruction moves through a fixed sequence of phases: fetch, decode, execute, and, where needed, one or two memory-access phases and a register writeback.

The supported operations are integer add, bitwise and, bitwise complement, three load forms, address generation, store, and a conditional branch on the condition flags. Each load form is either relative to the program counter, based on a register, or indirect through a pointer word. The core stops when it meets the halt trap word. It then raises a sticky halted output and makes no more memory writes. The flags are brought out so that a system or a test can see the sign of the last result.

Top module: `mc16_core`

## Requirements
- R1: A synchronous active-low reset sets the program counter to the RESET_VEC parameter (default 0x3000) and the flags to zero-only (`flags` = 3'b010). It clears `halted` and keeps `mem_we` low. During reset `mem_addr` shows RESET_VEC.
- R2: Opcode 0001 adds and opcode 0101 ands. The destination is in bits 11:9 and the first source in bits 8:6. When bit 5 is 1, the second operand is bits 4:0 sign-extended. When bit 5 is 0, the second operand is the register named in bits 2:0.
- R3: Opcode 1001 writes the bitwise complement of the register in bits 8:6 into the register in bits 11:9.
- R4: `flags` is {N,Z,P} with N in bit 2. After any write to a register (add, and, complement, any load, address generation), exactly one flag is set, chosen by the sign and zero-ness of the written value. Stores and branches leave the flags unchanged.
- R5: Opcode 0010 loads and opcode 0011 stores. Each uses the address (address of the instruction + 1) plus the sign-extended 9-bit field in bits 8:0. A store drives `mem_we` high for exactly one cycle, with the address and the register in bits 11:9 as data.
- R6: Opcode 0110 loads from the register in bits 8:6 plus the sign-extended 6-bit field in bits 5:0.
- R7: Opcode 1010 reads the word at the program-counter-relative address. It then uses that word as the address of a second read, and that second read supplies the destination value.
- R8: Opcode 1110 writes the program-counter-relative address itself into the destination, without any memory read.
- R9: Opcode 0000 holds a mask {n,z,p} in bits 11:9. It jumps to (its address + 1) plus the sign-extended bits 8:0 when the mask and the flags share a set bit. A mask of zero never jumps.
- R10: The word 0xF025 halts the core. `halted` rises and stays high until reset, with no further memory writes.
- R11: Add, and, complement, address generation, branch and halt each take 3 cycles. A store takes 4 cycles, a direct or register-based load 5, and an indirect load 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 16 | Word address for the memory access of this cycle |
| mem_wdata | output | 16 | Store data, valid while mem_we is high |
| mem_we | output | 1 | Write strobe for the memory |
| mem_rdata | input | 16 | Read data for the address presented one cycle earlier |
| halted | output | 1 | High once the halt word has executed |
| flags | output | 3 | Condition flags {N,Z,P} |

## Verification
The results of this core arrive at fixed cycle offsets. A store's write strobe falls in the fourth cycle of that instruction. `halted` rises exactly after the sum of the per-instruction cycle counts in R11 for the path the program takes, branches included. The scoreboard's monitor samples the write strobe on every falling edge, so each store is compared in the cycle it happens. The run loop counts falling edges from reset release until `halted`, and compares that count with the figure worked out by hand for each program. Register and flag results are made visible by storing registers at the end of each program and by reading `flags` after the halt.

// File: rtl/mc16_pkg.sv
`timescale 1ns/1ps
// mc16_pkg: shared constants, opcode values, phase and ALU-operation types,
// and sign-extension helpers for the multi-cycle core.
// Assumes a 16-bit word and eight registers (a power of two).
package mc16_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned NREG   = 8;
    localparam int unsigned RIDX_W = $clog2(NREG);
    localparam int unsigned OPC_W  = 4;

    localparam logic [OPC_W-1:0] OPC_BR   = 4'h0;
    localparam logic [OPC_W-1:0] OPC_ADD  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_LD   = 4'h2;
    localparam logic [OPC_W-1:0] OPC_ST   = 4'h3;
    localparam logic [OPC_W-1:0] OPC_AND  = 4'h5;
    localparam logic [OPC_W-1:0] OPC_LDR  = 4'h6;
    localparam logic [OPC_W-1:0] OPC_NOT  = 4'h9;
    localparam logic [OPC_W-1:0] OPC_LDI  = 4'hA;
    localparam logic [OPC_W-1:0] OPC_LEA  = 4'hE;
    localparam logic [OPC_W-1:0] OPC_TRAP = 4'hF;

    typedef enum logic [2:0] {
        PH_FETCH,
        PH_DECODE,
        PH_EXEC,
        PH_MEM,
        PH_IADR,
        PH_MEM2,
        PH_WB,
        PH_HALT
    } phase_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_AND,
        ALU_NOT,
        ALU_PASSB
    } alu_op_e;

    // Widen a 9-bit signed field to a word.
    function automatic logic [WORD_W-1:0] sext9(input logic [8:0] f);
        return {{(WORD_W-9){f[8]}}, f};
    endfunction

    // Widen a 6-bit signed field to a word.
    function automatic logic [WORD_W-1:0] sext6(input logic [5:0] f);
        return {{(WORD_W-6){f[5]}}, f};
    endfunction

    // Widen a 5-bit signed field to a word.
    function automatic logic [WORD_W-1:0] sext5(input logic [4:0] f);
        return {{(WORD_W-5){f[4]}}, f};
    endfunction

endpackage

// File: rtl/mc16_regfile.sv
`timescale 1ns/1ps
// mc16_regfile: general register array with two combinational read ports
// and one synchronous write port. Assumes N is a power of two.
module mc16_regfile #(
    parameter  int unsigned W  = 16,
    parameter  int unsigned N  = 8,
    localparam int unsigned AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra1,
    output logic [W-1:0]  rd1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd2
);

    logic [N-1:0][W-1:0] regs;

    // Clear all registers on reset, otherwise apply the single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else if (we) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];

endmodule

// File: rtl/mc16_alu.sv
`timescale 1ns/1ps
// mc16_alu: combinational result unit for add, and, complement and a
// pass-through of operand B (used for address generation).
module mc16_alu
    import mc16_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  alu_op_e       op,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y
);

    // Select the result for the requested operation.
    always_comb begin
        unique case (op)
            ALU_ADD:   y = a + b;
            ALU_AND:   y = a & b;
            ALU_NOT:   y = ~a;
            ALU_PASSB: y = b;
        endcase
    end

endmodule

// File: rtl/mc16_ccr.sv
`timescale 1ns/1ps
// mc16_ccr: condition register {N,Z,P} and branch-condition test.
// Assumes upd is asserted only in cycles that write a register.
module mc16_ccr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] val,
    input  logic [2:0]   mask,
    output logic [2:0]   flags,
    output logic         take
);

    logic is_zero;
    assign is_zero = (val == '0);

    // Reset to zero-only, then classify every written value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= 3'b010;
        end else if (upd) begin
            flags <= {val[W-1], is_zero, ~val[W-1] & ~is_zero};
        end
    end

    assign take = |(mask & flags);

    // R4: exactly one flag is set at all times after reset.
    a_r4_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags) == 1);

    // R4: without an update the flags hold.
    a_r4_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(flags));

endmodule

// File: rtl/mc16_core.sv
`timescale 1ns/1ps
// mc16_core: multi-cycle core. Sequences fetch, decode, execute, memory
// access (two accesses for the indirect load) and writeback.
// Assumes a memory that returns read data one cycle after the address and
// writes on the rising edge where mem_we is high.
module mc16_core
    import mc16_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_VEC = 16'h3000,
    parameter logic [7:0]        HALT_CODE = 8'h25
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              halted,
    output logic [2:0]        flags
);

    phase_e            phase, phase_nx;
    logic [WORD_W-1:0] pc, ir, mar;
    logic [OPC_W-1:0]  opc;

    logic is_add, is_and, is_not, is_ld, is_ldi, is_ldr, is_lea, is_st, is_br;
    logic is_stop;

    logic [RIDX_W-1:0] ra2;
    logic [WORD_W-1:0] rd1, rd2, opnd_b, alu_b, alu_y;
    logic [WORD_W-1:0] pc_rel, base_rel;
    logic              rf_we;
    logic [WORD_W-1:0] rf_wd;
    alu_op_e           alu_op;
    logic              br_take;

    // Opcode decode from the latched instruction word.
    assign opc     = ir[15:12];
    assign is_add  = (opc == OPC_ADD);
    assign is_and  = (opc == OPC_AND);
    assign is_not  = (opc == OPC_NOT);
    assign is_ld   = (opc == OPC_LD);
    assign is_ldi  = (opc == OPC_LDI);
    assign is_ldr  = (opc == OPC_LDR);
    assign is_lea  = (opc == OPC_LEA);
    assign is_st   = (opc == OPC_ST);
    assign is_br   = (opc == OPC_BR);
    assign is_stop = (opc == OPC_TRAP) && (ir[11:8] == 4'h0) && (ir[7:0] == HALT_CODE);

    // Second read port serves the store source or the register operand.
    assign ra2 = is_st ? ir[11:9] : ir[2:0];

    // Address arithmetic: pc already holds the incremented value here.
    assign pc_rel   = pc + sext9(ir[8:0]);
    assign base_rel = rd1 + sext6(ir[5:0]);

    // Operand B: immediate or register, or the computed address for LEA.
    assign opnd_b = ir[5] ? sext5(ir[4:0]) : rd2;
    assign alu_b  = is_lea ? pc_rel : opnd_b;

    // Choose the result operation from the decoded opcode.
    always_comb begin
        if (is_and)      alu_op = ALU_AND;
        else if (is_not) alu_op = ALU_NOT;
        else if (is_lea) alu_op = ALU_PASSB;
        else             alu_op = ALU_ADD;
    end

    // Register write: ALU-type results in execute, loaded data in writeback.
    assign rf_we = ((phase == PH_EXEC) && (is_add || is_and || is_not || is_lea))
                 || (phase == PH_WB);
    assign rf_wd = (phase == PH_WB) ? mem_rdata : alu_y;

    mc16_regfile #(.W(WORD_W), .N(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wa    (ir[11:9]),
        .wd    (rf_wd),
        .ra1   (ir[8:6]),
        .rd1   (rd1),
        .ra2   (ra2),
        .rd2   (rd2)
    );

    mc16_alu #(.W(WORD_W)) u_alu (
        .op (alu_op),
        .a  (rd1),
        .b  (alu_b),
        .y  (alu_y)
    );

    mc16_ccr #(.W(WORD_W)) u_ccr (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (rf_we),
        .val   (rf_wd),
        .mask  (ir[11:9]),
        .flags (flags),
        .take  (br_take)
    );

    // Next phase from the current phase and the decoded instruction.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_FETCH:  phase_nx = PH_DECODE;
            PH_DECODE: phase_nx = PH_EXEC;
            PH_EXEC: begin
                if (is_ld || is_ldi || is_ldr || is_st) phase_nx = PH_MEM;
                else if (is_stop)                      phase_nx = PH_HALT;
                else                                   phase_nx = PH_FETCH;
            end
            PH_MEM: begin
                if (is_st)       phase_nx = PH_FETCH;
                else if (is_ldi) phase_nx = PH_IADR;
                else             phase_nx = PH_WB;
            end
            PH_IADR:   phase_nx = PH_MEM2;
            PH_MEM2:   phase_nx = PH_WB;
            PH_WB:     phase_nx = PH_FETCH;
            PH_HALT:   phase_nx = PH_HALT;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_FETCH;
        else        phase <= phase_nx;
    end

    // Program counter: increment on fetch, redirect on a taken branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= RESET_VEC;
        end else if (phase == PH_FETCH) begin
            pc <= pc + 1'b1;
        end else if ((phase == PH_EXEC) && is_br && br_take) begin
            pc <= pc_rel;
        end
    end

    // Instruction latch on decode.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ir <= '0;
        else if (phase == PH_DECODE) ir <= mem_rdata;
    end

    // Memory address register: effective address, then the pointer for LDI.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar <= '0;
        end else if (phase == PH_EXEC) begin
            if (is_ldr) mar <= base_rel;
            else        mar <= pc_rel;
        end else if (phase == PH_IADR) begin
            mar <= mem_rdata;
        end
    end

    // Memory port and status outputs.
    assign mem_addr  = ((phase == PH_MEM) || (phase == PH_MEM2)) ? mar : pc;
    assign mem_we    = (phase == PH_MEM) && is_st;
    assign mem_wdata = rd2;
    assign halted    = (phase == PH_HALT);

    // R10: once halted, the core stays halted until reset.
    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R10: a halted core never writes memory.
    a_r10_quiet_halt: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R5: a store strobe lasts exactly one cycle.
    a_r5_store_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4: a store leaves the flags untouched.
    a_r4_store_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(flags));

    // R9: a branch with an empty mask does not move the program counter.
    a_r9_empty_mask_falls_through: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_EXEC && is_br && ir[11:9] == 3'b000) |=> (pc == $past(pc)));

    // R11: every fetch advances the program counter by one.
    a_r11_fetch_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH) |=> (pc == $past(pc) + 16'd1));

endmodule

// File: tb/sim_mc16_core.sv
`timescale 1ns/1ps
// sim_mc16_core: runs short programs from a bench-owned memory. A driver
// queues expected stores; a monitor compares each write strobe as it occurs.
module sim_mc16_core;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, halted;
    logic [2:0]  flags;

    always #5 clk = ~clk;

    mc16_core #(.RESET_VEC(16'h3000)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .halted    (halted),
        .flags     (flags)
    );

    // Memory model: 1024 words, one-cycle read latency, bench preload port.
    logic [15:0] mem [0:1023];
    logic        pl_we = 1'b0;
    logic [9:0]  pl_a  = '0;
    logic [15:0] pl_d  = '0;

    always @(posedge clk) begin
        if (pl_we)       mem[pl_a] <= pl_d;
        else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:0]];
    end

    // Scoreboard: written by the driver, read by the monitor through sb_rd.
    logic [15:0] sb_addr[$];
    logic [15:0] sb_data[$];
    string       sb_tag[$];
    int          sb_rd      = 0;
    int          mon_checks = 0;
    int          mon_fails  = 0;
    int          checks     = 0;
    int          fails      = 0;

    // Monitor: compare every store strobe against the next expected item.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && mem_we === 1'b1) begin
            mon_checks++;
            if (sb_rd >= sb_addr.size()) begin
                mon_fails++;
                $display("FAIL R5 unexpected store actual [%h]<=%h expected none",
                         mem_addr, mem_wdata);
            end else begin
                if (mem_addr !== sb_addr[sb_rd] || mem_wdata !== sb_data[sb_rd]) begin
                    mon_fails++;
                    $display("FAIL %s store actual [%h]<=%h expected [%h]<=%h",
                             sb_tag[sb_rd], mem_addr, mem_wdata,
                             sb_addr[sb_rd], sb_data[sb_rd]);
                end
                sb_rd++;
            end
        end
    end

    task automatic expect_store(input logic [15:0] a, input logic [15:0] d, input string tag);
        sb_addr.push_back(a);
        sb_data.push_back(d);
        sb_tag.push_back(tag);
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] d);
        pl_a  = a[9:0];
        pl_d  = d;
        pl_we = 1'b1;
        @(negedge clk);
        pl_we = 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) poke(16'(i), 16'h0000);
    endtask

    // Hold reset over one edge and check the reset state (R1).
    task automatic reset_and_check();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset address", mem_addr, 16'h3000);
        check("R1 reset halted", {15'b0, halted}, 16'h0000);
        check("R1 reset write strobe", {15'b0, mem_we}, 16'h0000);
        check("R1 reset flags", {13'b0, flags}, 16'h0002);
    endtask

    // Release reset, count cycles to halt, then check halt, flags and stores.
    task automatic run_prog(input string tag, input int exp_cyc, input logic [2:0] exp_flags);
        int cyc = 0;
        rst_n = 1'b1;
        while (halted !== 1'b1 && cyc < 2000) begin
            cyc++;
            @(negedge clk);
        end
        check({"R11 cycle count ", tag}, 16'(cyc), 16'(exp_cyc));
        check({"R10 halted ", tag}, {15'b0, halted}, 16'h0001);
        check({"R4 final flags ", tag}, {13'b0, flags}, {13'b0, exp_flags});
        repeat (4) @(negedge clk);
        check({"R10 halt sticky ", tag}, {15'b0, halted}, 16'h0001);
        check({"R5 all stores seen ", tag}, 16'(sb_rd), 16'(sb_addr.size()));
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #2000000;
        $display("FAIL watchdog expired actual running expected finished");
        $display("TB_RESULT checks=%0d failures=%0d",
                 checks + mon_checks + 1, fails + mon_fails + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        repeat (2) @(negedge clk);

        // Program 1: arithmetic, logic, complement, stores (R2 R3 R4 R5).
        clear_mem();
        reset_and_check();
        poke(16'h3000, 16'h5260); // R1 = R1 & 0
        poke(16'h3001, 16'h1262); // R1 = R1 + 2
        poke(16'h3002, 16'h1470); // R2 = R1 + (-16)
        poke(16'h3003, 16'h96BF); // R3 = ~R2
        poke(16'h3004, 16'h18C2); // R4 = R3 + R2 (register mode)
        poke(16'h3005, 16'h5B03); // R5 = R4 & R3 (register mode)
        poke(16'h3006, 16'h34F9); // store R2 -> 0x3100
        poke(16'h3007, 16'h36F9); // store R3 -> 0x3101
        poke(16'h3008, 16'h38F9); // store R4 -> 0x3102
        poke(16'h3009, 16'h3AF9); // store R5 -> 0x3103
        poke(16'h300A, 16'hF025); // halt
        expect_store(16'h3100, 16'hFFF2, "R2 negative immediate add");
        expect_store(16'h3101, 16'h000D, "R3 complement");
        expect_store(16'h3102, 16'hFFFF, "R2 register add");
        expect_store(16'h3103, 16'h000D, "R2 register and");
        run_prog("p1", 37, 3'b001);
        check("R5 stored word in memory", mem[10'h100], 16'hFFF2);

        // Program 2: direct, indirect, register-based loads and LEA (R6 R7 R8).
        rst_n = 1'b0;
        clear_mem();
        reset_and_check();
        poke(16'h3040, 16'h3042); // pointer word
        poke(16'h3041, 16'h8000);
        poke(16'h3042, 16'h1234);
        poke(16'h3000, 16'h2240); // R1 = mem[0x3041]
        poke(16'h3001, 16'hA43E); // R2 = mem[mem[0x3040]]
        poke(16'h3002, 16'hE63D); // R3 = 0x3040
        poke(16'h3003, 16'h68C2); // R4 = mem[R3 + 2]
        poke(16'h3004, 16'h6AFF); // R5 = mem[R3 - 1] (zero)
        poke(16'h3005, 16'h324A); // store R1 -> 0x3050
        poke(16'h3006, 16'h344A); // store R2 -> 0x3051
        poke(16'h3007, 16'h364A); // store R3 -> 0x3052
        poke(16'h3008, 16'h384A); // store R4 -> 0x3053
        poke(16'h3009, 16'h3A4A); // store R5 -> 0x3054
        poke(16'h300A, 16'hF025); // halt
        expect_store(16'h3050, 16'h8000, "R5 relative load");
        expect_store(16'h3051, 16'h1234, "R7 indirect load");
        expect_store(16'h3052, 16'h3040, "R8 address generation");
        expect_store(16'h3053, 16'h1234, "R6 base plus positive offset");
        expect_store(16'h3054, 16'h0000, "R6 base plus negative offset");
        run_prog("p2", 48, 3'b010);
        check("R8 pointer word not written", mem[10'h040], 16'h3042);

        // Program 3: branches, empty mask, backward loop (R9 R4).
        rst_n = 1'b0;
        clear_mem();
        reset_and_check();
        poke(16'h3000, 16'h5260); // R1 = 0 (Z)
        poke(16'h3001, 16'h0401); // branch on z: taken, skips next
        poke(16'h3002, 16'h1261); // R1 += 1 (must be skipped)
        poke(16'h3003, 16'h0A01); // branch on n|p: not taken
        poke(16'h3004, 16'h1265); // R1 += 5 (P)
        poke(16'h3005, 16'h0001); // empty mask: never taken
        poke(16'h3006, 16'h147A); // R2 = R1 - 6 (N)
        poke(16'h3007, 16'h0601); // branch on z|p: not taken
        poke(16'h3008, 16'h3237); // store R1 -> 0x3040
        poke(16'h3009, 16'h3437); // store R2 -> 0x3041
        poke(16'h300A, 16'h127F); // R1 -= 1
        poke(16'h300B, 16'h03FE); // branch on p back to 0x300A
        poke(16'h300C, 16'h3235); // store R1 -> 0x3042
        poke(16'h300D, 16'hF025); // halt
        expect_store(16'h3040, 16'h0005, "R9 taken skip and untaken fall-through");
        expect_store(16'h3041, 16'hFFFF, "R9 empty mask not taken");
        expect_store(16'h3042, 16'h0000, "R9 backward loop exit");
        run_prog("p3", 66, 3'b010);

        // Reset after a halt clears the halted state (R1).
        reset_and_check();

        $display("TB_RESULT checks=%0d failures=%0d",
                 checks + mon_checks, fails + mon_fails);
        $finish;
    end

endmodule